// File: doc/BRIEF.md
# Multi-PHY Cell Transmit Rate Scheduler

This block paces cell transmission for four PHY channels that share one transmitter. A programmable prescaler turns the system clock into a common rate tick. The divisor is set for the fastest PHY. For example, a 133 MHz clock feeding a 155.52 Mbps link with 53-byte cells needs a divisor of 362. Each PHY owns an 8-bit control word. In internal mode, a per-PHY 7-bit down-counter divides the shared tick again by (reload + 1). A 10 Mbps PHY next to a 155 Mbps one would use reload 14, which divides the tick by 15.

In external mode, a PHY's requests come from its own request pin instead. The pin is synchronized, and each rising edge becomes a single request pulse. Requests from several PHYs may assert in the same cycle. Downstream logic arbitrates between them.

Top module: `cell_rate_sched`

## Requirements
- R1: After reset, `tx_req` is all zero, the divisor is 0, and every PHY is in external mode with reload 0.
- R2: A PHY control write (`cfg_we`) targets the PHY given by `cfg_sel`. Bit 7 of `cfg_data` is the mode: 1 selects internal and 0 selects external. Bits 6:0 are the reload value R.
- R3: The prescaler divisor N, written with `div_we`, restarts the prescaler. With N' = max(N,1), a tick is raised N' clocks after the write and then every N' clocks. N = 0 and N = 1 both give a tick every clock.
- R4: In internal mode, the PHY issues one one-cycle request for every R+1 ticks. The first request comes on the (R+1)th tick after its control write.
- R5: A control write reloads that PHY's counter at once. It suppresses that PHY's request in the write cycle, so the new rate counts from the next tick.
- R6: In external mode, each rising edge of `ext_req[i]` gives exactly one cycle of `tx_req[i]`. If `ext_req[i]` is set just before clock edge e, the pulse follows edge e+2.
- R7: An external request held high for many cycles produces only one pulse.
- R8: The PHYs run independently, and their requests may assert in the same cycle.
- R9: A PHY in external mode ignores the rate tick. A PHY in internal mode ignores its `ext_req` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | PHY control write strobe |
| cfg_sel | input | 2 | PHY index for the write |
| cfg_data | input | 8 | Mode bit 7, reload bits 6:0 |
| div_we | input | 1 | Prescaler divisor write strobe |
| div_data | input | 12 | Prescaler divisor N |
| ext_req | input | 4 | Asynchronous external request, one per PHY |
| tx_req | output | 4 | One-cycle cell transmit requests |

## Verification
The timing is fixed by the write edges. Ticks fall on edges p+k·N' after a divisor write at edge p. An internal PHY written at edge k first pulses on the (R+1)th such tick edge after k, then every (R+1)·N' edges. An external rising edge set before edge e shows up after edge e+2.

Each write or stimulus task records the edge index at which it landed and pushes the exact edge numbers of the expected pulses into a queue. When a PHY is rewritten, the task drops that PHY's pending items at or after the write edge. A monitor samples at every falling clock edge. It pops items whose edge matches the current one, and any pulse on an edge with no queued item counts as a failure.

// File: rtl/cell_rate_sched.sv
module cell_rate_sched #(
  parameter int NPHY  = 4,
  parameter int RLD_W = 7,
  parameter int DIV_W = 12,
  localparam int SEL_W = $clog2(NPHY),
  localparam int CFG_W = RLD_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_data,
  input  logic [NPHY-1:0]  ext_req,
  output logic [NPHY-1:0]  tx_req
);

  logic [DIV_W-1:0] div_q, pre_cnt;
  logic [DIV_W-1:0] pre_last;
  logic             tick;

  assign pre_last = (div_q > DIV_W'(1)) ? div_q - DIV_W'(1) : '0;
  assign tick     = !div_we && (pre_cnt == pre_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '0;
      pre_cnt <= '0;
    end else if (div_we) begin
      div_q   <= div_data;
      pre_cnt <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + DIV_W'(1);
    end
  end

  logic [NPHY-1:0]            mode_v;
  logic [NPHY-1:0][RLD_W-1:0] rld_v, cnt_v;

  for (genvar g = 0; g < NPHY; g++) begin : g_phy
    logic             mode, req, s1, s2, s3;
    logic [RLD_W-1:0] rld, cnt;
    logic             wr;

    assign wr = cfg_we && (cfg_sel == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mode <= 1'b0;
        rld  <= '0;
        cnt  <= '0;
        req  <= 1'b0;
        s1   <= 1'b0;
        s2   <= 1'b0;
        s3   <= 1'b0;
      end else begin
        s1 <= ext_req[g];
        s2 <= s1;
        s3 <= s2;
        if (wr) begin
          mode <= cfg_data[CFG_W-1];
          rld  <= cfg_data[RLD_W-1:0];
          cnt  <= cfg_data[RLD_W-1:0];
          req  <= 1'b0;
        end else if (!mode) begin
          cnt <= rld;
          req <= s2 && !s3;
        end else begin
          req <= tick && (cnt == '0);
          if (tick) cnt <= (cnt == '0) ? rld : cnt - RLD_W'(1);
        end
      end
    end

    assign tx_req[g] = req;
    assign mode_v[g] = mode;
    assign rld_v[g]  = rld;
    assign cnt_v[g]  = cnt;
  end

endmodule

// File: rtl/cell_rate_sched_chk.sv
module cell_rate_sched_chk #(
  parameter int NPHY  = 4,
  parameter int RLD_W = 7,
  parameter int DIV_W = 12,
  localparam int SEL_W = $clog2(NPHY)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_we,
  input logic [SEL_W-1:0]           cfg_sel,
  input logic                       tick,
  input logic [DIV_W-1:0]           pre_cnt,
  input logic [DIV_W-1:0]           pre_last,
  input logic [NPHY-1:0]            mode_v,
  input logic [NPHY-1:0][RLD_W-1:0] rld_v,
  input logic [NPHY-1:0][RLD_W-1:0] cnt_v,
  input logic [NPHY-1:0]            tx_req
);

  a_r3_prescale_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= pre_last);

  for (genvar g = 0; g < NPHY; g++) begin : g_chk
    a_r4_pulse_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req[g] && mode_v[g]) |-> $past(tick));

    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_v[g] <= rld_v[g]);

    a_r5_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == SEL_W'(g)) |=> !tx_req[g]);

    a_r7_ext_single: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req[g] && !mode_v[g]) |=> !tx_req[g]);

    a_r9_ext_holds_cnt: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_v[g] |-> (cnt_v[g] == rld_v[g]));
  end

endmodule

bind cell_rate_sched cell_rate_sched_chk #(
  .NPHY(NPHY), .RLD_W(RLD_W), .DIV_W(DIV_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .tick(tick), .pre_cnt(pre_cnt), .pre_last(pre_last),
  .mode_v(mode_v), .rld_v(rld_v), .cnt_v(cnt_v), .tx_req(tx_req)
);

// File: tb/tb_cell_rate_sched.sv
`timescale 1ns/1ps
module tb_cell_rate_sched;
  logic       clk = 0, rst_n = 0;
  logic       cfg_we = 0, div_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [7:0] cfg_data = 0;
  logic [11:0] div_data = 0;
  logic [3:0] ext_req = 0;
  logic [3:0] tx_req;

  cell_rate_sched dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .div_we(div_we), .div_data(div_data), .ext_req(ext_req),
    .tx_req(tx_req));

  always #10 clk = ~clk;

  int ecnt = 0;
  int checks = 0, fails = 0;
  int q[$];            // item = ((edge*4+phy)*2 + kind), kind 0 = R4 timer, 1 = R6 external
  int pstart = 0, ndiv = 1;
  logic [3:0] is_int = 0;
  bit done = 0;

  always @(posedge clk) ecnt <= ecnt + 1;

  always @(negedge clk) if (rst_n && !done) begin
    for (int p = 0; p < 4; p++) begin
      int hit;
      hit = -1;
      for (int i = 0; i < q.size(); i++)
        if ((q[i] >> 1) == ecnt * 4 + p) hit = i;
      if (hit >= 0) begin
        checks++;
        if (tx_req[p] !== 1'b1) begin
          fails++;
          $display("FAIL %s phy%0d edge %0d: tx_req=%b expected 1",
                   (q[hit] & 1) ? "R6" : "R4", p, ecnt, tx_req[p]);
        end
        q.delete(hit);
      end else if (tx_req[p] !== 1'b0) begin
        fails++;
        $display("FAIL R8/R9 phy%0d edge %0d: tx_req=%b expected 0", p, ecnt, tx_req[p]);
      end
    end
  end

  task automatic drop(int p, int e);
    for (int i = q.size() - 1; i >= 0; i--)
      if (((q[i] >> 1) % 4) == p && (q[i] >> 3) >= e) q.delete(i);
  endtask

  task automatic wr_div(int n);
    @(negedge clk); div_we = 1; div_data = 12'(n);
    @(posedge clk); #1; div_we = 0;
    pstart = ecnt; ndiv = (n <= 1) ? 1 : n;
  endtask

  task automatic wr_phy(int p, logic [7:0] d);
    int e, j, t, r;
    @(negedge clk); cfg_we = 1; cfg_sel = 2'(p); cfg_data = d;
    @(posedge clk); #1; cfg_we = 0;
    e = ecnt;
    drop(p, e);
    is_int[p] = d[7];
    if (d[7]) begin
      r = int'(d[6:0]);
      j = (e - pstart) / ndiv + 1;
      t = pstart + (j + r) * ndiv;
      while (t < e + 3000) begin
        q.push_back((t * 4 + p) * 2);
        t += (r + 1) * ndiv;
      end
    end
  endtask

  task automatic ext_pulse(int p, int hold);
    int e;
    @(posedge clk); #1; ext_req[p] = 1'b1;
    e = ecnt + 1;
    if (!is_int[p]) q.push_back(((e + 2) * 4 + p) * 2 + 1);
    repeat (hold) @(posedge clk);
    #1; ext_req[p] = 1'b0;
  endtask

  task automatic all_ext();
    for (int p = 0; p < 4; p++) wr_phy(p, 8'h00);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: expired, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    repeat (3) @(negedge clk);
    checks++;
    if (tx_req !== 4'b0) begin
      fails++; $display("FAIL R1 reset: tx_req=%b expected 0000", tx_req);
    end
    // R1/R6/R7: default external mode, held-high input gives one pulse
    ext_pulse(0, 8);
    ext_pulse(2, 1);
    repeat (6) @(posedge clk);

    // R3 N=1, R4 several reloads, R8 simultaneous, R9 ext ignored when internal
    wr_div(1);
    wr_phy(0, 8'h80);
    wr_phy(1, 8'h83);
    wr_phy(2, 8'h8E);
    ext_pulse(1, 3);
    ext_pulse(3, 2);
    repeat (60) @(posedge clk);
    all_ext();
    repeat (5) @(posedge clk);

    // R3 N=5, R4 max reload, R5 rewrite mid-run, R6 external beside timers
    wr_div(5);
    wr_phy(0, 8'h82);
    wr_phy(3, 8'hFF);
    ext_pulse(1, 4);
    repeat (37) @(posedge clk);
    wr_phy(0, 8'h80);
    repeat (40) @(posedge clk);
    ext_pulse(1, 20);
    repeat (1300) @(posedge clk);
    all_ext();
    // R9: ticks running, external PHYs stay quiet
    repeat (30) @(posedge clk);

    // R3 N=0 behaves as N=1; R2 select of the last PHY
    wr_div(0);
    wr_phy(3, 8'h81);
    wr_phy(2, 8'h82);
    repeat (40) @(posedge clk);
    all_ext();
    repeat (10) @(posedge clk);

    @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++; $display("FAIL R4 pending: %0d expected pulses missing, expected 0", q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule